// File: doc/BRIEF.md
# Sampling Converter Serial Readout Interface

This block is the digital side of a 16-bit sampling converter. A host starts a conversion with a rising edge on the convert strobe. At that moment the level of the serial data input picks the operating mode. A conversion timer stands in for the analog core and keeps the core enable high for a fixed number of system clocks. When the timer expires, the parallel result word is captured and becomes available for readout on the serial data output, one bit per falling edge of the host serial clock.

Two modes are available:

- **Chip-select mode.** The part drives its output only while the strobe or the data input is held low. This serves a three-wire host that uses the strobe as select, and a four-wire host that uses the data input as a separate read enable.
- **Chain mode.** The output is always driven. Bits arriving on the data input are shifted in behind the local word, so several converters can share one line.

Either mode can place a high start bit ahead of the word. The host can use that bit as a done flag.

All host pins are assumed to be already synchronous to `clk_i`. Serial clock edges are detected by oversampling, so each serial clock phase must last at least one system clock.

Top module: `conv_readout_if`

## Requirements
- R1: At an accepted rising edge of `cnv_i`, the mode is taken from `sdi_i` as sampled one clock earlier. A 1 selects chip-select mode and a 0 selects chain mode. In chain mode `sdo_oe_o` stays 1.
- R2: When `sdi_i` and `cnv_i` rise in the same cycle, chain mode results.
- R3: `core_active_o` rises in the cycle after an accepted strobe edge. It stays high for exactly `CONV_CYCLES` clocks and then falls by itself.
- R4: A strobe rising edge while `core_active_o` is high starts nothing and does not lengthen the conversion.
- R5: `result_i` is captured as the conversion ends and is sent most significant bit first. Each detected falling edge of `sck_i` advances one bit. `sdo_o` otherwise changes only when a conversion starts or ends.
- R6: In chip-select mode, `sdo_oe_o` is 1 exactly while `cnv_i` or `sdi_i` is low. While `sdo_oe_o` is 0, `sdo_o` is 0.
- R7: In chip-select mode, if `cnv_i` or `sdi_i` is low on the clock that ends the conversion, `sdo_o` shows a start bit of value 1 ahead of the MSB. The first falling edge of `sck_i` removes that bit.
- R8: In chain mode, if `sck_i` was high at the accepted strobe edge, a start bit of value 1 precedes the MSB.
- R9: Without a start bit, the MSB is on `sdo_o` as soon as the conversion has ended and the output is enabled.
- R10: In chain mode, each data-shifting `sck_i` falling edge loads `sdi_i` behind the word. That bit reaches `sdo_o` `DATA_W` shifts later. The fall that removes a start bit loads nothing.
- R11: While `core_active_o` is high, `sdo_o` is 0 and `sck_i` falling edges are ignored. The following readout still holds the full word.
- R12: After reset the core is idle, the mode is chip-select and `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_i | input | 1 | Convert strobe; in chip-select mode also the three-wire select |
| sck_i | input | 1 | Host serial clock |
| sdi_i | input | 1 | Mode select, four-wire read enable, or chain input |
| result_i | input | DATA_W | Parallel result from the analog core |
| core_active_o | output | 1 | Analog core enable, high during a conversion |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Output enable for the serial data pad; 0 means high impedance |

## Verification
The checker watches several rules on every clock:

- the exact conversion length and the ignored strobe edges;
- the quiet output during a conversion;
- that `sdo_o` moves only after a serial clock fall or a conversion boundary;
- that a strobe edge with `sdi_i` low always yields a driven output;
- that chip-select mode releases the pad while both pins are high.

The bench scenarios are what show the bit order, the start-bit decisions in both modes, the pass-through delay in chain mode and the four-wire handshake. Those depend on the captured word and on pin levels at particular instants.

// File: rtl/conv_readout_pkg.sv
package conv_readout_pkg;
  typedef enum logic {
    MODE_CHAIN = 1'b0,
    MODE_CS    = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/cr_pin_reg.sv
module cr_pin_reg #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/cr_conv_timer.sv
module cr_conv_timer #(
  parameter int CONV_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = active_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i && !active_o) begin
      active_o <= 1'b1;
      cnt_q    <= CNT_W'(CONV_CYCLES - 1);
    end else if (done_o) begin
      active_o <= 1'b0;
    end else if (active_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cr_shifter.sv
module cr_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              start_bit_i,
  input  logic              shift_i,
  input  logic              fill_i,
  output logic              bit_o
);
  logic [DATA_W-1:0] sr_q;
  logic              start_q;

  assign bit_o = start_q ? 1'b1 : sr_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      start_q <= 1'b0;
    end else if (load_i) begin
      sr_q    <= data_i;
      start_q <= start_bit_i;
    end else if (shift_i) begin
      // a pending start bit is consumed without moving the word
      if (start_q) start_q <= 1'b0;
      else         sr_q    <= {sr_q[DATA_W-2:0], fill_i};
    end
  end
endmodule

// File: rtl/conv_readout_if.sv
module conv_readout_if
  import conv_readout_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              core_active_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_q;
  logic             cnv_q, sck_q, sdi_q;
  logic             cnv_rise, sck_fall, start_acc;
  logic             conv_done, shift_bit;
  logic             selected, busy_en, ready_q, chain_busy_q;
  rd_mode_e         mode_q;

  cr_pin_reg #(.W(PIN_W), .RST_VAL(3'b100)) u_pins (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, sck_i, cnv_i}),
    .q_o   (pins_q)
  );

  assign {sdi_q, sck_q, cnv_q} = pins_q;
  assign cnv_rise  = cnv_i & ~cnv_q;
  assign sck_fall  = sck_q & ~sck_i;
  assign start_acc = cnv_rise & ~core_active_o;

  cr_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cnv_rise),
    .active_o(core_active_o),
    .done_o  (conv_done)
  );

  // mode from the level one clock before the strobe edge: sdi tied to cnv reads low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= MODE_CS;
      chain_busy_q <= 1'b0;
      ready_q      <= 1'b0;
    end else begin
      if (start_acc) begin
        mode_q       <= sdi_q ? MODE_CS : MODE_CHAIN;
        chain_busy_q <= sck_q;
      end
      if (start_acc)      ready_q <= 1'b0;
      else if (conv_done) ready_q <= 1'b1;
    end
  end

  assign selected  = ~cnv_i | ~sdi_i;
  assign busy_en   = (mode_q == MODE_CS) ? selected : chain_busy_q;
  assign shift_bit = sck_fall & ready_q & ((mode_q == MODE_CHAIN) | selected);

  logic sh_bit;

  cr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (conv_done),
    .data_i     (result_i),
    .start_bit_i(busy_en),
    .shift_i    (shift_bit),
    .fill_i     ((mode_q == MODE_CHAIN) & sdi_i),
    .bit_o      (sh_bit)
  );

  assign sdo_oe_o = (mode_q == MODE_CHAIN) | selected;
  assign sdo_o    = sdo_oe_o & ~core_active_o & sh_bit;
endmodule

// File: rtl/conv_readout_chk.sv
module conv_readout_chk #(
  parameter int CONV_CYCLES = 20
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cnv_i,
  input logic sck_i,
  input logic sdi_i,
  input logic core_active_o,
  input logic sdo_o,
  input logic sdo_oe_o
);
  localparam int RUN_W = $clog2(CONV_CYCLES + 1) + 1;

  logic [RUN_W-1:0] run_cnt;
  logic             sck_d, fell_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt <= '0;
      sck_d   <= 1'b0;
      fell_d  <= 1'b0;
    end else begin
      run_cnt <= core_active_o ? run_cnt + 1'b1 : '0;
      sck_d   <= sck_i;
      fell_d  <= sck_d & ~sck_i;
    end
  end

  // R3, R4: never longer than the set length
  a_r3_max_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_active_o |-> (run_cnt < RUN_W'(CONV_CYCLES)));

  a_r3_full_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_active_o) |-> ($past(run_cnt) == RUN_W'(CONV_CYCLES - 1)));

  a_r11_quiet_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_active_o |-> !sdo_o);

  a_r1_chain_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cnv_i) && !$past(sdi_i) && !core_active_o) |=> sdo_oe_o);

  a_r6_cs_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cnv_i) && $past(sdi_i) && !core_active_o) |=> (!(cnv_i && sdi_i) || !sdo_oe_o));

  a_r5_sdo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_active_o && !$past(core_active_o) && !fell_d && sdo_oe_o && $past(sdo_oe_o))
      |-> $stable(sdo_o));
endmodule

bind conv_readout_if conv_readout_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnv_i        (cnv_i),
  .sck_i        (sck_i),
  .sdi_i        (sdi_i),
  .core_active_o(core_active_o),
  .sdo_o        (sdo_o),
  .sdo_oe_o     (sdo_oe_o)
);

// File: tb/tb_conv_readout_if.sv
module tb_conv_readout_if;
  localparam int DW = 16;
  localparam int CC = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnv = 1'b0, sck = 1'b0, sdi = 1'b1;
  logic [DW-1:0] result = '0;
  logic          core_active, sdo, sdo_oe;

  int  n_chk = 0, n_fail = 0;
  bit  exp_q[$];
  bit  done = 1'b0;

  always #2 clk = ~clk;

  conv_readout_if #(.DATA_W(DW), .CONV_CYCLES(CC)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cnv_i        (cnv),
    .sck_i        (sck),
    .sdi_i        (sdi),
    .result_i     (result),
    .core_active_o(core_active),
    .sdo_o        (sdo),
    .sdo_oe_o     (sdo_oe)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic push_word(bit start, logic [DW-1:0] w);
    if (start) exp_q.push_back(1'b1);
    for (int i = DW - 1; i >= 0; i--) exp_q.push_back(w[i]);
  endtask

  task automatic push_pat(logic [31:0] p, int n);
    for (int i = 0; i < n; i++) exp_q.push_back(p[i]);
  endtask

  // monitor side: pops one expectation per serial bit
  task automatic read_bits(int n, string req, bit drive, logic [31:0] pat);
    for (int i = 0; i < n; i++) begin
      bit e;
      @(negedge clk);
      e = exp_q.pop_front();
      check(req, {31'b0, sdo}, {31'b0, e});
      if (drive) sdi = pat[i];
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state, chip-select with cnv low drives 0
    check("R12 active", {31'b0, core_active}, 0);
    check("R12 sdo", {31'b0, sdo}, 0);
    check("R12 oe", {31'b0, sdo_oe}, 1);

    // three-wire, no start bit, ignored second strobe
    result = 16'hA5C3;
    sdi = 1'b1;
    @(negedge clk);
    cnv = 1'b1;
    cnt = 0;
    for (int i = 0; i < CC + 6; i++) begin
      @(negedge clk);
      if (core_active) cnt++;
      if (i == 3) cnv = 1'b0;
      if (i == 4) cnv = 1'b1;
    end
    check("R3 R4 length", cnt, CC);
    check("R6 released", {31'b0, sdo_oe}, 0);
    check("R6 released sdo", {31'b0, sdo}, 0);
    cnv = 1'b0;
    @(negedge clk);
    check("R6 selected", {31'b0, sdo_oe}, 1);
    check("R9 msb first", {31'b0, sdo}, 1);
    push_word(1'b0, 16'hA5C3);
    read_bits(DW, "R5 three-wire", 1'b0, 0);

    // three-wire with start bit; SCK falls during conversion ignored
    result = 16'h5A3C;
    cnv = 1'b1;
    @(negedge clk);
    cnv = 1'b0;
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
      repeat (2) @(negedge clk);
    end
    check("R11 quiet", {31'b0, sdo}, 0);
    check("R11 driven", {31'b0, sdo_oe}, 1);
    repeat (CC) @(negedge clk);
    check("R7 start bit", {31'b0, sdo}, 1);
    push_word(1'b1, 16'h5A3C);
    read_bits(DW + 1, "R7 R11 read", 1'b0, 0);

    // four-wire: cnv held high, sdi as read enable
    result = 16'h3C96;
    sdi = 1'b1;
    @(negedge clk);
    cnv = 1'b1;
    repeat (CC + 3) @(negedge clk);
    check("R6 four-wire idle", {31'b0, sdo_oe}, 0);
    sdi = 1'b0;
    @(negedge clk);
    check("R6 four-wire enable", {31'b0, sdo_oe}, 1);
    check("R9 four-wire msb", {31'b0, sdo}, 0);
    push_word(1'b0, 16'h3C96);
    read_bits(DW, "R5 four-wire", 1'b0, 0);
    sdi = 1'b1;
    @(negedge clk);
    check("R6 four-wire release", {31'b0, sdo_oe}, 0);
    check("R6 four-wire sdo", {31'b0, sdo}, 0);

    // sdi tied to cnv: chain mode, pass-through
    result = 16'hC35A;
    cnv = 1'b0;
    sdi = 1'b0;
    repeat (2) @(negedge clk);
    cnv = 1'b1;
    sdi = 1'b1;
    repeat (CC + 3) @(negedge clk);
    check("R2 tied chain", {31'b0, sdo_oe}, 1);
    check("R9 chain msb", {31'b0, sdo}, 1);
    push_word(1'b0, 16'hC35A);
    push_pat(32'h0000_000D, 4);
    read_bits(DW + 4, "R10 pass-through", 1'b1, 32'h0000_000D);

    // chain with start bit from SCK high at strobe edge
    result = 16'h1E87;
    cnv = 1'b0;
    sdi = 1'b0;
    sck = 1'b1;
    repeat (2) @(negedge clk);
    cnv = 1'b1;
    @(negedge clk);
    sck = 1'b0;
    repeat (CC + 3) @(negedge clk);
    check("R1 chain oe", {31'b0, sdo_oe}, 1);
    check("R8 start bit", {31'b0, sdo}, 1);
    push_word(1'b1, 16'h1E87);
    push_pat(32'h0000_0001, 1);
    read_bits(DW + 2, "R8 R10 chain read", 1'b1, 32'h0000_0002);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule